// File: doc/BRIEF.md
# LCD panel timing generator

This block drives the timing side of a parallel LCD panel. It produces horizontal sync, vertical sync, data-enable, the pixel column and row being shown, a one-cycle frame-start pulse and a flag that selects which pixel clock edge the downstream data path should launch on. The block advances one pixel position on each clock cycle where the pixel clock enable is high. Between enables it holds its outputs.

Software programs the timing through a single-cycle write port that reaches three 32-bit words: a horizontal word, a vertical word and a polarity word. Every line runs sync, back porch, active and front porch in that order. Every frame runs the same four phases counted in lines. Horizontal lengths are stored minus one and the active width is counted in blocks of 16 pixels. Vertical porches are stored as plain line counts, while vertical sync and active height are stored minus one. Writes go into a staging copy, and the staging copy is transferred to the working copy only as a frame ends. A frame is therefore never drawn with a mix of old and new timing.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is held, hsync, vsync, de, frame_start and pclk_edge_inv are 0 and pix_x and pix_y are 0, whatever pix_ce does.
- R2: Horizontal word (cfg_sel 0): bits [7:2] = B, [15:8] = S, [23:16] = F and [31:24] = K. Each line is S+1 sync pixels, then K+1 back-porch pixels, then 16*(B+1) active pixels, then F+1 front-porch pixels. With no inversion, hsync is 1 exactly during the sync pixels.
- R3: Vertical word (cfg_sel 1): bits [9:0] = A, [15:10] = S, [23:16] = F and [31:24] = K. Each frame is S+1 sync lines, then K back-porch lines, then A+1 active lines, then F front-porch lines. K or F may be 0. With no inversion, vsync is 1 exactly during the sync lines.
- R4: The raw data enable is 1 only when the line is in its active lines and the pixel lies within the first min(C+1, 16*(B+1)) active pixels of its line. C is taken from bits [25:16] of the polarity word (cfg_sel 2).
- R5: While the raw data enable is 1, pix_x is the pixel offset from the start of the active pixels and pix_y is the line offset from the start of the active lines. Otherwise both are 0.
- R6: Polarity word bit 12 inverts hsync, bit 11 inverts vsync and bit 14 inverts de. Bit 13 appears directly on pclk_edge_inv.
- R7: frame_start is high for exactly one clock, on the cycle whose outputs show the first sync pixel of a frame.
- R8: A write changes only the staging copy. The new timing takes effect from the first pixel of the next frame, so the current frame finishes with the old timing.
- R9: In a cycle after pix_ce was low, hsync, vsync, de, pix_x, pix_y and pclk_edge_inv keep their previous values and frame_start is 0.
- R10: The following writes are dropped and leave the timing unchanged: a horizontal word with bit 0 or bit 1 set, a polarity word with any of bits [10:0], bit 15 or bits [31:26] set, and any write with cfg_sel 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel clock enable; one pixel position per high cycle |
| cfg_wr | input | 1 | Write strobe for the timing words |
| cfg_sel | input | 2 | Word select: 0 horizontal, 1 vertical, 2 polarity, 3 none |
| cfg_wdata | input | 32 | Word being written |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_x | output | XW | Column inside the active area |
| pix_y | output | YW | Row inside the active area |
| frame_start | output | 1 | One-clock pulse at the first sync pixel of a frame |
| pclk_edge_inv | output | 1 | Pixel clock drive-edge select |

## Verification
The bench uses the default XW = YW = 10 and the field widths fixed by the word layout, which gives 11-bit line and frame counters. It programs small phase lengths: porches and syncs of a few pixels or lines, and one or two 16-pixel blocks. This keeps a frame to a few hundred pixel positions, so dozens of frames and configuration swaps fit in a short run. Those swaps include zero vertical porches, a data-enable span clipped below the active width, all inversions set, and writes issued mid-frame. Randomly gated pix_ce and deliberately malformed writes reach the hold and drop behaviour on many different phase positions.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  localparam int REG_W        = 32;
  localparam int BLK_PIX_LOG2 = 4;   // active width counted in 16-pixel blocks
  localparam int HBLK_W       = 6;
  localparam int HPH_W        = 8;
  localparam int VACT_W       = 10;
  localparam int VSW_W        = 6;
  localparam int VPH_W        = 8;
  localparam int CPL_W        = 10;

  // horizontal word field positions
  localparam int H_BLK_LSB  = 2;
  localparam int H_SYNC_LSB = 8;
  localparam int H_FP_LSB   = 16;
  localparam int H_BP_LSB   = 24;
  // vertical word field positions
  localparam int V_ACT_LSB  = 0;
  localparam int V_SYNC_LSB = 10;
  localparam int V_FP_LSB   = 16;
  localparam int V_BP_LSB   = 24;
  // polarity word bit positions
  localparam int P_VINV_BIT = 11;
  localparam int P_HINV_BIT = 12;
  localparam int P_EDGE_BIT = 13;
  localparam int P_DINV_BIT = 14;
  localparam int P_CPL_LSB  = 16;
  localparam logic [REG_W-1:0] P_RSVD_MASK = 32'hFC00_87FF;

  localparam int H_MAX  = 3 * (1 << HPH_W) + ((1 << HBLK_W) << BLK_PIX_LOG2);
  localparam int V_MAX  = (1 << VSW_W) + 2 * ((1 << VPH_W) - 1) + (1 << VACT_W);
  localparam int HCNT_W = $clog2(H_MAX + 1);
  localparam int VCNT_W = $clog2(V_MAX + 1);

  typedef logic [HCNT_W-1:0] hcnt_t;
  typedef logic [VCNT_W-1:0] vcnt_t;

  typedef enum logic [1:0] {
    SEL_HORZ = 2'd0,
    SEL_VERT = 2'd1,
    SEL_POL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [HBLK_W-1:0] act_blk;
    logic [HPH_W-1:0]  sync_m1;
    logic [HPH_W-1:0]  fp_m1;
    logic [HPH_W-1:0]  bp_m1;
  } horz_cfg_t;

  typedef struct packed {
    logic [VACT_W-1:0] act_m1;
    logic [VSW_W-1:0]  sync_m1;
    logic [VPH_W-1:0]  fp;
    logic [VPH_W-1:0]  bp;
  } vert_cfg_t;

  typedef struct packed {
    logic [CPL_W-1:0] cpl_m1;
    logic             inv_h;
    logic             inv_v;
    logic             inv_de;
    logic             inv_edge;
  } pol_cfg_t;

  typedef struct packed {
    horz_cfg_t h;
    vert_cfg_t v;
    pol_cfg_t  p;
  } timing_cfg_t;

  // ---- word checks and decoding ----
  function automatic logic horz_word_ok(logic [REG_W-1:0] w);
    return w[H_BLK_LSB-1:0] == '0;
  endfunction

  function automatic logic pol_word_ok(logic [REG_W-1:0] w);
    return (w & P_RSVD_MASK) == '0;
  endfunction

  function automatic horz_cfg_t horz_decode(logic [REG_W-1:0] w);
    horz_cfg_t c;
    c.act_blk = w[H_BLK_LSB  +: HBLK_W];
    c.sync_m1 = w[H_SYNC_LSB +: HPH_W];
    c.fp_m1   = w[H_FP_LSB   +: HPH_W];
    c.bp_m1   = w[H_BP_LSB   +: HPH_W];
    return c;
  endfunction

  function automatic vert_cfg_t vert_decode(logic [REG_W-1:0] w);
    vert_cfg_t c;
    c.act_m1  = w[V_ACT_LSB  +: VACT_W];
    c.sync_m1 = w[V_SYNC_LSB +: VSW_W];
    c.fp      = w[V_FP_LSB   +: VPH_W];
    c.bp      = w[V_BP_LSB   +: VPH_W];
    return c;
  endfunction

  function automatic pol_cfg_t pol_decode(logic [REG_W-1:0] w);
    pol_cfg_t c;
    c.cpl_m1   = w[P_CPL_LSB +: CPL_W];
    c.inv_h    = w[P_HINV_BIT];
    c.inv_v    = w[P_VINV_BIT];
    c.inv_de   = w[P_DINV_BIT];
    c.inv_edge = w[P_EDGE_BIT];
    return c;
  endfunction

  // ---- horizontal arithmetic (pixel positions within a line) ----
  function automatic hcnt_t h_sync_len(horz_cfg_t c);
    return hcnt_t'(c.sync_m1) + hcnt_t'(1);
  endfunction

  function automatic hcnt_t h_act_start(horz_cfg_t c);
    return h_sync_len(c) + hcnt_t'(c.bp_m1) + hcnt_t'(1);
  endfunction

  function automatic hcnt_t h_act_len(horz_cfg_t c);
    return (hcnt_t'(c.act_blk) + hcnt_t'(1)) << BLK_PIX_LOG2;
  endfunction

  function automatic hcnt_t h_total(horz_cfg_t c);
    return h_act_start(c) + h_act_len(c) + hcnt_t'(c.fp_m1) + hcnt_t'(1);
  endfunction

  function automatic hcnt_t de_len(horz_cfg_t h, pol_cfg_t p);
    hcnt_t a;
    hcnt_t d;
    a = h_act_len(h);
    d = hcnt_t'(p.cpl_m1) + hcnt_t'(1);
    return (d < a) ? d : a;
  endfunction

  // ---- vertical arithmetic (line positions within a frame) ----
  function automatic vcnt_t v_sync_len(vert_cfg_t c);
    return vcnt_t'(c.sync_m1) + vcnt_t'(1);
  endfunction

  function automatic vcnt_t v_act_start(vert_cfg_t c);
    return v_sync_len(c) + vcnt_t'(c.bp);
  endfunction

  function automatic vcnt_t v_act_end(vert_cfg_t c);
    return v_act_start(c) + vcnt_t'(c.act_m1) + vcnt_t'(1);
  endfunction

  function automatic vcnt_t v_total(vert_cfg_t c);
    return v_act_end(c) + vcnt_t'(c.fp);
  endfunction

endpackage

// File: rtl/lcdt_axis_counter.sv
module lcdt_axis_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         last
);

  logic [W-1:0] cnt_q;

  assign last = (cnt_q == total - W'(1));
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= last ? '0 : cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/lcdt_cfg_regs.sv
module lcdt_cfg_regs
  import lcdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              frame_end,
  output timing_cfg_t       pend_cfg,
  output timing_cfg_t       live_cfg
);

  timing_cfg_t pend_q;
  timing_cfg_t live_q;
  logic        h_take;
  logic        v_take;
  logic        p_take;

  always_comb begin
    h_take = wr_en && (wr_sel == SEL_HORZ) && horz_word_ok(wr_data);
    v_take = wr_en && (wr_sel == SEL_VERT);
    p_take = wr_en && (wr_sel == SEL_POL) && pol_word_ok(wr_data);
  end

  // staging copy: written at any time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      if (h_take) pend_q.h <= horz_decode(wr_data);
      if (v_take) pend_q.v <= vert_decode(wr_data);
      if (p_take) pend_q.p <= pol_decode(wr_data);
    end
  end

  // working copy: only replaced as a frame ends
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (frame_end) begin
      live_q <= pend_q;
    end
  end

  assign pend_cfg = pend_q;
  assign live_cfg = live_q;

endmodule

// File: rtl/lcdt_out_stage.sv
module lcdt_out_stage
  import lcdt_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_ce,
  input  hcnt_t         h_cnt,
  input  vcnt_t         v_cnt,
  input  timing_cfg_t   cfg,
  output logic          hs_lvl,
  output logic          vs_lvl,
  output logic          de_lvl,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic          frame_start,
  output logic          edge_inv
);

  localparam int NPOL = 3;  // 0 hsync, 1 vsync, 2 data enable

  logic            hs_now;
  logic            vs_now;
  logic            h_win;
  logic            v_win;
  logic            de_now;
  logic            first_px;
  hcnt_t           h_start;
  vcnt_t           v_start;
  logic [NPOL-1:0] lvl_now;
  logic [NPOL-1:0] inv_now;
  logic [NPOL-1:0] lvl_q;
  logic [NPOL-1:0] pin_q;
  logic [XW-1:0]   x_q;
  logic [YW-1:0]   y_q;
  logic            fs_q;
  logic            edge_q;

  always_comb begin
    h_start  = h_act_start(cfg.h);
    v_start  = v_act_start(cfg.v);
    hs_now   = h_cnt < h_sync_len(cfg.h);
    vs_now   = v_cnt < v_sync_len(cfg.v);
    h_win    = (h_cnt >= h_start) && (h_cnt < h_start + de_len(cfg.h, cfg.p));
    v_win    = (v_cnt >= v_start) && (v_cnt < v_act_end(cfg.v));
    de_now   = h_win && v_win;
    first_px = (h_cnt == '0) && (v_cnt == '0);
    lvl_now  = {de_now, vs_now, hs_now};
    inv_now  = {cfg.p.inv_de, cfg.p.inv_v, cfg.p.inv_h};
  end

  // one flop pair per polarity-controlled signal
  for (genvar g = 0; g < NPOL; g++) begin : g_pol
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl_q[g] <= 1'b0;
        pin_q[g] <= 1'b0;
      end else if (pix_ce) begin
        lvl_q[g] <= lvl_now[g];
        pin_q[g] <= lvl_now[g] ^ inv_now[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      edge_q <= 1'b0;
    end else if (pix_ce) begin
      x_q    <= de_now ? XW'(h_cnt - h_start) : '0;
      y_q    <= de_now ? YW'(v_cnt - v_start) : '0;
      edge_q <= cfg.p.inv_edge;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= pix_ce && first_px;
  end

  assign hs_lvl      = lvl_q[0];
  assign vs_lvl      = lvl_q[1];
  assign de_lvl      = lvl_q[2];
  assign hsync       = pin_q[0];
  assign vsync       = pin_q[1];
  assign de          = pin_q[2];
  assign pix_x       = x_q;
  assign pix_y       = y_q;
  assign frame_start = fs_q;
  assign edge_inv    = edge_q;

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_ce,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic          frame_start,
  output logic          pclk_edge_inv
);

  timing_cfg_t pend_cfg;
  timing_cfg_t live_cfg;
  hcnt_t       h_cnt;
  vcnt_t       v_cnt;
  logic        h_last;
  logic        v_last;
  logic        line_end;
  logic        frame_end;
  logic        hs_lvl;
  logic        vs_lvl;
  logic        de_lvl;

  assign line_end  = pix_ce && h_last;
  assign frame_end = line_end && v_last;

  lcdt_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_sel   (cfg_sel),
    .wr_data  (cfg_wdata),
    .frame_end(frame_end),
    .pend_cfg (pend_cfg),
    .live_cfg (live_cfg)
  );

  lcdt_axis_counter #(.W(HCNT_W)) u_hcnt (
    .clk  (clk),
    .rst_n(rst_n),
    .step (pix_ce),
    .total(h_total(live_cfg.h)),
    .cnt  (h_cnt),
    .last (h_last)
  );

  lcdt_axis_counter #(.W(VCNT_W)) u_vcnt (
    .clk  (clk),
    .rst_n(rst_n),
    .step (line_end),
    .total(v_total(live_cfg.v)),
    .cnt  (v_cnt),
    .last (v_last)
  );

  lcdt_out_stage #(.XW(XW), .YW(YW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_ce     (pix_ce),
    .h_cnt      (h_cnt),
    .v_cnt      (v_cnt),
    .cfg        (live_cfg),
    .hs_lvl     (hs_lvl),
    .vs_lvl     (vs_lvl),
    .de_lvl     (de_lvl),
    .hsync      (hsync),
    .vsync      (vsync),
    .de         (de),
    .pix_x      (pix_x),
    .pix_y      (pix_y),
    .frame_start(frame_start),
    .edge_inv   (pclk_edge_inv)
  );

endmodule

// File: rtl/lcdt_chk.sv
module lcdt_chk
  import lcdt_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ce,
  input logic          cfg_wr,
  input logic [1:0]    cfg_sel,
  input logic          frame_end,
  input hcnt_t         h_cnt,
  input vcnt_t         v_cnt,
  input timing_cfg_t   pend_cfg,
  input timing_cfg_t   live_cfg,
  input logic          hs_lvl,
  input logic          vs_lvl,
  input logic          de_lvl,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] pix_y,
  input logic          frame_start
);

  // R2
  hcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_cnt < h_total(live_cfg.h));

  // R3
  vcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_cnt < v_total(live_cfg.v));

  // R4
  de_not_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_lvl |-> !hs_lvl && !vs_lvl);

  // R5
  pos_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de_lvl |-> (pix_x == '0) && (pix_y == '0));

  // R7
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R7
  fs_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> hs_lvl && vs_lvl);

  // R8
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(live_cfg));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> $stable({hsync, vsync, de, pix_x, pix_y}) && !frame_start);

  // R10
  bad_sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && (cfg_sel == 2'd3) |=> $stable(pend_cfg));

endmodule

bind lcd_timing_gen lcdt_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_ce     (pix_ce),
  .cfg_wr     (cfg_wr),
  .cfg_sel    (cfg_sel),
  .frame_end  (frame_end),
  .h_cnt      (h_cnt),
  .v_cnt      (v_cnt),
  .pend_cfg   (pend_cfg),
  .live_cfg   (live_cfg),
  .hs_lvl     (hs_lvl),
  .vs_lvl     (vs_lvl),
  .de_lvl     (de_lvl),
  .hsync      (hsync),
  .vsync      (vsync),
  .de         (de),
  .pix_x      (pix_x),
  .pix_y      (pix_y),
  .frame_start(frame_start)
);

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_ce = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        hsync, vsync, de, frame_start, pclk_edge_inv;
  logic [9:0]  pix_x, pix_y;

  always #10 clk = ~clk;  // 50 MHz

  lcd_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y),
    .frame_start(frame_start), .pclk_edge_inv(pclk_edge_inv)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit run_checks = 1'b0;
  bit drop_seen  = 1'b0;
  int ce_pct = 100;

  // ---- expected-value helpers, one per field of the requirements ----
  function automatic int f_hsync(logic [31:0] w); return int'(w[15:8]) + 1;  endfunction
  function automatic int f_hback(logic [31:0] w); return int'(w[31:24]) + 1; endfunction
  function automatic int f_hfront(logic [31:0] w); return int'(w[23:16]) + 1; endfunction
  function automatic int f_hact(logic [31:0] w); return (int'(w[7:2]) + 1) * 16; endfunction
  function automatic int f_vsync(logic [31:0] w); return int'(w[15:10]) + 1; endfunction
  function automatic int f_vback(logic [31:0] w); return int'(w[31:24]); endfunction
  function automatic int f_vfront(logic [31:0] w); return int'(w[23:16]); endfunction
  function automatic int f_vact(logic [31:0] w); return int'(w[9:0]) + 1; endfunction
  function automatic int f_dclk(logic [31:0] w); return int'(w[25:16]) + 1; endfunction

  function automatic logic [31:0] mk_h(int s, int k, int blk, int f);
    return {8'(k), 8'(f), 8'(s), 6'(blk), 2'b00};
  endfunction
  function automatic logic [31:0] mk_v(int a, int s, int f, int k);
    return {8'(k), 8'(f), 6'(s), 10'(a)};
  endfunction
  function automatic logic [31:0] mk_p(int c, bit dinv, bit edg, bit hinv, bit vinv);
    return {6'd0, 10'(c), 1'b0, dinv, edg, hinv, vinv, 11'd0};
  endfunction

  function automatic bit word_ok(logic [1:0] sel, logic [31:0] w);
    if (sel == 2'd3) return 1'b0;
    if (sel == 2'd0) return w[1:0] == 2'b00;
    if (sel == 2'd2) return (w & 32'hFC00_87FF) == 32'd0;
    return 1'b1;
  endfunction

  // ---- reference model ----
  logic [31:0] m_pend [3];
  logic [31:0] m_live [3];
  int  m_h, m_v;
  bit  m_prev_ce;
  logic e_hs, e_vs, e_de, e_fs, e_edge;
  int  e_x, e_y;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_pend[i] = 32'd0; m_live[i] = 32'd0; end
      m_h = 0; m_v = 0; m_prev_ce = 1'b1;
      e_hs = 0; e_vs = 0; e_de = 0; e_fs = 0; e_edge = 0; e_x = 0; e_y = 0;
    end else begin
      m_prev_ce = pix_ce;
      if (pix_ce) begin
        int rx, ry;
        bit hin, vin, dn;
        rx  = m_h - f_hsync(m_live[0]) - f_hback(m_live[0]);
        ry  = m_v - f_vsync(m_live[1]) - f_vback(m_live[1]);
        hin = (rx >= 0) && (rx < f_hact(m_live[0])) && (rx < f_dclk(m_live[2]));
        vin = (ry >= 0) && (ry < f_vact(m_live[1]));
        dn  = hin && vin;
        e_hs   = (m_h < f_hsync(m_live[0])) ^ m_live[2][12];
        e_vs   = (m_v < f_vsync(m_live[1])) ^ m_live[2][11];
        e_de   = dn ^ m_live[2][14];
        e_edge = m_live[2][13];
        e_x    = dn ? rx : 0;
        e_y    = dn ? ry : 0;
        e_fs   = (m_h == 0) && (m_v == 0);
        m_h++;
        if (m_h == f_hsync(m_live[0]) + f_hback(m_live[0]) + f_hact(m_live[0]) + f_hfront(m_live[0])) begin
          m_h = 0;
          m_v++;
          if (m_v == f_vsync(m_live[1]) + f_vback(m_live[1]) + f_vact(m_live[1]) + f_vfront(m_live[1])) begin
            m_v = 0;
            for (int i = 0; i < 3; i++) m_live[i] = m_pend[i];
          end
        end
      end else begin
        e_fs = 1'b0;
      end
      if (cfg_wr && word_ok(cfg_sel, cfg_wdata)) m_pend[cfg_sel] = cfg_wdata;
    end
  end

  task automatic chk(string tag, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, name, act, exp);
    end
  endtask

  function automatic string pick(string base);
    if (drop_seen) return "R10";
    if (m_pend[0] != m_live[0] || m_pend[1] != m_live[1] || m_pend[2] != m_live[2]) return "R8";
    if (!m_prev_ce) return "R9";
    return base;
  endfunction

  always @(negedge clk) begin
    if (rst_n && run_checks && !done) begin
      chk(pick("R2"), "hsync", int'(hsync), int'(e_hs));
      chk(pick("R3"), "vsync", int'(vsync), int'(e_vs));
      chk(pick("R4"), "de", int'(de), int'(e_de));
      chk(pick("R5"), "pix_x", int'(pix_x), e_x);
      chk(pick("R5"), "pix_y", int'(pix_y), e_y);
      chk(pick("R7"), "frame_start", int'(frame_start), int'(e_fs));
      chk(pick("R6"), "pclk_edge_inv", int'(pclk_edge_inv), int'(e_edge));
    end
  end

  // ---- stimulus ----
  task automatic step_cycle();
    @(posedge clk);
    #1;
    cfg_wr = 1'b0;
    pix_ce = ($urandom % 100) < ce_pct;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step_cycle();
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] w);
    @(posedge clk);
    #1;
    pix_ce    = ($urandom % 100) < ce_pct;
    cfg_wr    = 1'b1;
    cfg_sel   = sel;
    cfg_wdata = w;
    drop_seen = !word_ok(sel, w);
  endtask

  task automatic rand_cfg(bit spoil);
    logic [31:0] hw, vw, pw;
    int which;
    hw = mk_h($urandom % 4, $urandom % 4, $urandom % 2, $urandom % 4);
    vw = mk_v($urandom % 4, $urandom % 3, $urandom % 3, $urandom % 3);
    pw = mk_p($urandom % 40, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    which = $urandom % 3;
    run($urandom % 200);
    wr(2'd0, hw);
    run($urandom % 50);
    wr(2'd1, vw);
    run($urandom % 50);
    wr(2'd2, pw);
    if (spoil) begin
      run($urandom % 50);
      if (which == 0)      wr(2'd0, hw | 32'h1);
      else if (which == 1) wr(2'd2, pw | 32'h8000_0000);
      else                 wr(2'd3, 32'hFFFF_FFFF);
    end
    run(1500);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset holds every output low even with pix_ce active
    pix_ce = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1", "hsync", int'(hsync), 0);
    chk("R1", "vsync", int'(vsync), 0);
    chk("R1", "de", int'(de), 0);
    chk("R1", "pix_x", int'(pix_x), 0);
    chk("R1", "pix_y", int'(pix_y), 0);
    chk("R1", "frame_start", int'(frame_start), 0);
    chk("R1", "pclk_edge_inv", int'(pclk_edge_inv), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    run_checks = 1'b1;
    // reset timing, full-rate enable
    run(300);
    // R2 R3 R4: directed timing, data clocks equal to active width
    wr(2'd0, mk_h(1, 2, 0, 1));
    wr(2'd1, mk_v(2, 0, 0, 0));
    wr(2'd2, mk_p(15, 0, 0, 0, 0));
    run(1200);
    // R6 R4: all inversions, data span clipped to 4 pixels, zero porches
    ce_pct = 80;
    wr(2'd0, mk_h(0, 0, 1, 0));
    wr(2'd1, mk_v(3, 1, 0, 0));
    wr(2'd2, mk_p(3, 1, 1, 1, 1));
    run(1500);
    // R10: malformed writes mid-frame must not change the timing
    wr(2'd0, mk_h(3, 3, 0, 3) | 32'h2);
    run(20);
    wr(2'd2, mk_p(20, 0, 0, 0, 0) | 32'h0000_0400);
    run(20);
    wr(2'd3, mk_h(2, 2, 1, 2));
    run(1500);
    // R8: mid-frame rewrite takes effect only at the next frame
    ce_pct = 100;
    wr(2'd1, mk_v(1, 2, 2, 2));
    run(1500);
    // random configurations, some with a spoiled write
    for (int r = 0; r < 10; r++) begin
      ce_pct = 50 + ($urandom % 51);
      rand_cfg(($urandom % 4) == 0);
    end
    // R9: sparse pixel enable
    ce_pct = 20;
    wr(2'd2, mk_p(10, 0, 1, 0, 1));
    run(1500);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog R1..: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule